// File: doc/BRIEF.md
# Two-Channel Memory-to-Memory DMA Engine

This block copies data between two regions of memory on behalf of a processor. It has two independent channels. Channel 0 serves a transmit data port and channel 1 serves a receive data port. Software programs each channel with a source address, a destination address, a unit count, a unit size and a mode, and then starts it. A channel starts either at once on a software command or, when it is armed for requests, on the rising edges of its own request line.

Each unit is moved as a read cycle on a single-master memory bus. A one-word holding register keeps the data between that read cycle and the following write cycle. After each unit both addresses advance by the unit size and the count drops by one. In block mode one start moves the whole count and keeps the bus. In single mode each unit releases the bus. When both channels want the bus, grants alternate. At the end of a transfer the channel raises a done flag and its interrupt line. Both stay high until software clears the flag.

Top module: `dma2ch`

## Requirements
- R1: After reset both channels are idle. All their registers read zero, `mem_req` is low and `irq` is 0.
- R2: Writing CTRL with bit 0 set and bit 4 clear starts a software transfer. Each unit reads at the source address, then writes the same data at the destination address. After the transfer SRC and DST read back advanced by count × unit size.
- R3: The CTRL size field (bits 2:1) selects the unit: 0 = byte, 1 = half word, 2 = word. The size is presented on `mem_size`. Exactly that many bytes move per unit, data right-aligned on the bus, and the addresses step by 1, 2 or 4.
- R4: A start or an arm is refused when SRC or DST is not aligned to the unit size, when the size code is 3, or when CNT is 0. A refused start sets the error flag (CTRL bit 9), leaves busy (CTRL bit 0) at 0 and issues no bus cycle. No bus cycle is ever issued at a misaligned address.
- R5: When the last unit completes, busy clears and done (CTRL bit 8) sets. `irq[c]` follows done. It stays high until software writes 1 to CTRL bit 8. Writing 1 to bit 9 clears the error flag.
- R6: When CTRL bit 4 is set and bit 3 is clear, the channel is armed in single request mode. Each rising edge of `dreq[c]` moves exactly one unit. A request held high does not move more.
- R7: When CTRL bits 4 and 3 are both set, the channel is armed in block request mode. One rising edge of `dreq[c]` moves the whole count.
- R8: When both channels request the bus at a grant point, the channel not served last is granted. Two single-mode channels therefore alternate unit by unit.
- R9: While a channel is busy, writes to its SRC, DST and CNT and new start commands are ignored.
- R10: Once `mem_req` is raised, it stays high with a stable address and direction until `mem_ack`.

Register map: `cfg_addr[2]` selects the channel and `cfg_addr[1:0]` selects SRC (0), DST (1), CNT (2) or CTRL (3). CTRL bit 0 is the start and busy bit, bits 2:1 are the size, bit 3 is block mode, bit 4 arms for requests, bit 8 is done and bit 9 is error. Bits 8 and 9 are cleared by writing 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Channel and register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | 2 | Per-channel transfer requests |
| mem_req | output | 1 | Bus cycle request |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Unit size code |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned |
| mem_ack | input | 1 | Cycle completion |
| irq | output | 2 | Per-channel completion interrupt |

## Verification
A wrong address or count register shows up at the ports within one unit. It appears as bytes landing in the wrong place or as a stale SRC/DST readback once the transfer ends. A lost or extra request edge leaves the count off by one, and this reads back right after the pulse. A mishandled grant pointer reverses the order of destination writes on the very next unit. The bench logs the order of write addresses to catch this. A missing refusal shows as a bus cycle within two clocks of the bad start.

// File: rtl/dma2ch.sv
module dma2ch #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [1:0]    dreq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic [1:0]    irq
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t             st;
  logic [AW-1:0]   src [2];
  logic [AW-1:0]   dst [2];
  logic [CW-1:0]   cnt [2];
  logic [1:0]      sz  [2];
  logic [1:0]      blk, den, busy, go, done, err, dq;
  logic            cur, last;
  logic [31:0]     hold;
  logic [1:0]      req;
  logic            pick;

  function automatic logic aligned(input logic [AW-1:0] a, input logic [1:0] s);
    return (s == 2'd0) || (s == 2'd1 && !a[0]) || (s == 2'd2 && a[1:0] == 2'b00);
  endfunction

  function automatic logic [AW-1:0] step(input logic [1:0] s);
    return AW'(1) << s;
  endfunction

  assign req  = busy & go;
  assign pick = (req == 2'b11) ? ~last : req[1];

  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_WR) ? dst[cur] : src[cur];
  assign mem_size  = sz[cur];
  assign mem_wdata = hold;
  assign irq       = done;

  always_comb begin
    logic c;
    c = cfg_addr[2];
    case (cfg_addr[1:0])
      2'd0:    cfg_rdata = 32'(src[c]);
      2'd1:    cfg_rdata = 32'(dst[c]);
      2'd2:    cfg_rdata = 32'(cnt[c]);
      default: cfg_rdata = {22'b0, err[c], done[c], 3'b0, den[c], blk[c], sz[c], busy[c]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        src[c] <= '0; dst[c] <= '0; cnt[c] <= '0; sz[c] <= '0;
      end
      blk <= '0; den <= '0; busy <= '0; go <= '0; done <= '0; err <= '0; dq <= '0;
    end else begin
      dq <= dreq;
      for (int c = 0; c < 2; c++) begin
        if (cfg_we && cfg_addr[2] == c[0]) begin
          case (cfg_addr[1:0])
            2'd0: if (!busy[c]) src[c] <= cfg_wdata[AW-1:0];
            2'd1: if (!busy[c]) dst[c] <= cfg_wdata[AW-1:0];
            2'd2: if (!busy[c]) cnt[c] <= cfg_wdata[CW-1:0];
            default: begin
              if (cfg_wdata[8]) done[c] <= 1'b0;
              if (cfg_wdata[9]) err[c]  <= 1'b0;
              if (!busy[c]) begin
                sz[c]  <= cfg_wdata[2:1];
                blk[c] <= cfg_wdata[3];
                den[c] <= cfg_wdata[4];
                if (cfg_wdata[0] || cfg_wdata[4]) begin
                  if (cfg_wdata[2:1] != 2'd3 && cnt[c] != '0 &&
                      aligned(src[c], cfg_wdata[2:1]) && aligned(dst[c], cfg_wdata[2:1])) begin
                    busy[c] <= 1'b1;
                    go[c]   <= !cfg_wdata[4];
                  end else begin
                    err[c] <= 1'b1;
                  end
                end
              end
            end
          endcase
        end
        if (st == S_WR && mem_ack && cur == c[0]) begin
          src[c] <= src[c] + step(sz[c]);
          dst[c] <= dst[c] + step(sz[c]);
          cnt[c] <= cnt[c] - 1'b1;
          if (cnt[c] == CW'(1)) begin
            busy[c] <= 1'b0;
            done[c] <= 1'b1;
            go[c]   <= 1'b0;
          end else if (den[c] && !blk[c]) begin
            go[c] <= 1'b0;
          end
        end
        if (busy[c] && den[c] && dreq[c] && !dq[c]) go[c] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= 1'b0; last <= 1'b1; hold <= '0;
    end else begin
      case (st)
        S_IDLE: if (|req) begin
          cur <= pick;
          st  <= S_RD;
        end
        S_RD: if (mem_ack) begin
          hold <= mem_rdata;
          st   <= S_WR;
        end
        default: if (mem_ack) begin
          last <= cur;
          st   <= (blk[cur] && cnt[cur] != CW'(1)) ? S_RD : S_IDLE;
        end
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R4
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_size != 2'd3 && aligned(mem_addr, mem_size));

  // R4
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err[0]) |-> !busy[0]);

  // R5
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done[0]) |-> $fell(busy[0]));

  // R3
  src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WR && mem_ack && !cur |=> src[0] - $past(src[0]) == step(sz[0]));

  // R8
  rr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && req == 2'b11 |=> cur == !$past(last));
endmodule

// File: tb/dma2ch_tb.sv
module dma2ch_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [1:0]  dreq = 0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size, irq;

  logic [7:0]  mem [256];
  logic [7:0]  ref_mem [256];
  logic [31:0] wlog [32];
  int          nlog = 0, nbus = 0;
  int          vecs = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma2ch u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq));

  always_comb begin
    logic [7:0] a;
    a = mem_addr[7:0];
    case (mem_size)
      2'd0:    mem_rdata = {24'b0, mem[a]};
      2'd1:    mem_rdata = {16'b0, mem[8'(a+1)], mem[a]};
      default: mem_rdata = {mem[8'(a+3)], mem[8'(a+2)], mem[8'(a+1)], mem[a]};
    endcase
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) mem_ack <= 1'b0;
    else mem_ack <= mem_req & ~mem_ack;
    if (mem_req) nbus <= nbus + 1;
    if (mem_req && mem_we && mem_ack) begin
      mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (mem_size >= 2'd1) mem[8'(mem_addr[7:0]+1)] <= mem_wdata[15:8];
      if (mem_size == 2'd2) begin
        mem[8'(mem_addr[7:0]+2)] <= mem_wdata[23:16];
        mem[8'(mem_addr[7:0]+3)] <= mem_wdata[31:24];
      end
      if (nlog < 32) wlog[nlog] <= mem_addr;
      nlog <= nlog + 1;
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp<=100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int rg, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_addr = {ch[0], rg[1:0]}; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input int ch, input int rg, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = {ch[0], rg[1:0]};
    #1 v = cfg_rdata;
  endtask

  task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d, input int n);
    wr(ch, 0, s); wr(ch, 1, d); wr(ch, 2, n);
  endtask

  task automatic wait_irq(input int ch, input string r);
    int k = 0;
    while (!irq[ch] && k < 500) begin @(negedge clk); k++; end
    chk(r, irq[ch], 1'b1);
  endtask

  task automatic cmp_bytes(input string r, input int s, input int d, input int n);
    for (int i = 0; i < n; i++) chk(r, mem[d+i], ref_mem[s+i]);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq", irq, 0);
    chk("R1 mem_req", mem_req, 0);
    for (int ch = 0; ch < 2; ch++)
      for (int rg = 0; rg < 4; rg++) begin rd(ch, rg, v); chk("R1 reg", v, 0); end
  endtask

  task automatic t_word_block;
    logic [31:0] v;
    setup(0, 32'h00, 32'h80, 4);
    wr(0, 3, 32'h0000_000D);
    wait_irq(0, "R5 irq");
    cmp_bytes("R2 data", 8'h00, 8'h80, 16);
    chk("R2 no overrun", mem[8'h90], 8'h00);
    rd(0, 0, v); chk("R2 src end", v, 32'h10);
    rd(0, 1, v); chk("R2 dst end", v, 32'h90);
    rd(0, 3, v); chk("R5 done busy", {v[8], v[0]}, 2'b10);
    repeat (5) @(negedge clk);
    chk("R5 irq holds", irq[0], 1'b1);
    wr(0, 3, 32'h100);
    chk("R5 irq clear", irq[0], 1'b0);
  endtask

  task automatic t_sizes;
    logic [31:0] v;
    setup(1, 32'h21, 32'hA3, 3);
    wr(1, 3, 32'h1);
    wait_irq(1, "R3 byte irq");
    cmp_bytes("R3 byte", 8'h21, 8'hA3, 3);
    chk("R3 byte bound", mem[8'hA6], 8'h00);
    rd(1, 1, v); chk("R3 byte step", v, 32'hA6);
    wr(1, 3, 32'h100);
    setup(0, 32'h12, 32'hB2, 2);
    wr(0, 3, 32'h3);
    wait_irq(0, "R3 half irq");
    cmp_bytes("R3 half", 8'h12, 8'hB2, 4);
    chk("R3 half bound", mem[8'hB6], 8'h00);
    rd(0, 0, v); chk("R3 half step", v, 32'h16);
    wr(0, 3, 32'h100);
  endtask

  task automatic t_refuse;
    logic [31:0] v;
    int b;
    setup(0, 32'h01, 32'h88, 2);
    b = nbus;
    wr(0, 3, 32'h5);
    repeat (10) @(negedge clk);
    rd(0, 3, v); chk("R4 misalign err", {v[9], v[0]}, 2'b10);
    chk("R4 no bus", nbus, b);
    wr(0, 3, 32'h200);
    rd(0, 3, v); chk("R5 err clear", v[9], 1'b0);
    wr(0, 0, 32'h04);
    wr(0, 3, 32'h7);
    rd(0, 3, v); chk("R4 bad size", {v[9], v[0]}, 2'b10);
    wr(0, 3, 32'h200);
    wr(0, 2, 0);
    wr(0, 3, 32'h1);
    rd(0, 3, v); chk("R4 zero count", {v[9], v[0]}, 2'b10);
    repeat (5) @(negedge clk);
    chk("R4 no bus end", nbus, b);
    wr(0, 3, 32'h200);
  endtask

  task automatic t_dreq_single;
    logic [31:0] v;
    setup(1, 32'h40, 32'hC0, 3);
    wr(1, 3, 32'h10);
    repeat (20) @(negedge clk);
    rd(1, 2, v); chk("R6 waits", v, 3);
    wr(1, 2, 9);
    wr(1, 0, 32'h44);
    rd(1, 2, v); chk("R9 cnt ignored", v, 3);
    rd(1, 0, v); chk("R9 src ignored", v, 32'h40);
    dreq[1] = 1;
    repeat (20) @(negedge clk);
    rd(1, 2, v); chk("R6 one unit", v, 2);
    chk("R6 moved", mem[8'hC0], ref_mem[8'h40]);
    chk("R6 not more", mem[8'hC1], 8'h00);
    for (int p = 0; p < 2; p++) begin
      dreq[1] = 0; @(negedge clk); dreq[1] = 1;
      repeat (10) @(negedge clk);
    end
    dreq[1] = 0;
    wait_irq(1, "R6 irq");
    cmp_bytes("R6 data", 8'h40, 8'hC0, 3);
    wr(1, 3, 32'h100);
  endtask

  task automatic t_dreq_block;
    setup(0, 32'h30, 32'hC8, 4);
    wr(0, 3, 32'h18);
    repeat (5) @(negedge clk);
    chk("R7 waits", mem[8'hC8], 8'h00);
    dreq[0] = 1; @(negedge clk); dreq[0] = 0;
    wait_irq(0, "R7 irq");
    cmp_bytes("R7 data", 8'h30, 8'hC8, 4);
    wr(0, 3, 32'h100);
  endtask

  task automatic t_rr;
    setup(0, 32'h50, 32'hD0, 3);
    setup(1, 32'h60, 32'hE0, 3);
    @(negedge clk);
    nlog = 0;
    wr(0, 3, 32'h1);
    wr(1, 3, 32'h1);
    wait_irq(0, "R8 irq0");
    wait_irq(1, "R8 irq1");
    chk("R8 count", nlog, 6);
    for (int i = 0; i < 6; i++)
      chk("R8 order", wlog[i][7:4], (i % 2 == 0) ? 4'hD : 4'hE);
    cmp_bytes("R8 data0", 8'h50, 8'hD0, 3);
    cmp_bytes("R8 data1", 8'h60, 8'hE0, 3);
    wr(0, 3, 32'h100); wr(1, 3, 32'h100);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = (i < 128) ? 8'(i * 7 + 3) : 8'h00;
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_word_block;
    t_sizes;
    t_refuse;
    t_dreq_single;
    t_dreq_block;
    t_rr;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule